// File: doc/BRIEF.md
# Cascaded Column Driver Line Loader

This block sits on the host side of a chain of cascaded column driver chips that share one parallel data bus. When it gets a line-start pulse, it drives the chain enable of the first chip. It then pulls pixel bytes from a ready/valid stream and puts each byte on the bus, giving one shift-clock pulse per byte. The total number of pulses is the chip count times the shift clocks per chip. After the last pulse it raises the line strobe, which latches the whole line into the chips' output stage. A done pulse follows once the strobe has ended.

All edge spacing is counted in system clock cycles and set by parameters. These counts cover the shift-clock high and low phases, the gap from a strobe fall to the next first shift-clock fall, the gap from the last shift-clock fall to the strobe, the strobe width and the minimum strobe period. Each byte changes only on a rising shift-clock edge, so the byte is stable for a whole phase on each side of the falling edge that the chips sample. When the stream has no byte ready, the shift clock simply waits in its low phase. It never emits a partial pulse.

The controller walks through seven named states:
- `S_IDLE`: waiting. A line-start pulse moves it to `S_LOAD`.
- `S_LOAD`: shift clock low. It accepts a byte and moves to `S_HIGH` once the low phase, the strobe-to-clock gap and a valid byte all allow it.
- `S_HIGH`: shift clock high. After the high count it goes to `S_TAIL` on the last byte of the line, and back to `S_LOAD` otherwise.
- `S_TAIL`: waits for the clock-to-strobe gap and the strobe period, then moves to `S_STB`.
- `S_STB`: strobe high. After the strobe width it moves to `S_FIN`.
- `S_FIN`: one cycle with the strobe low, then `S_DONE`.
- `S_DONE`: the done pulse, then back to `S_IDLE`.

Top module: `colchain_line_loader`

## Requirements
- R1: While reset is held and right after it is released, `sck`, `stb`, `done`, `chain_en` and `in_ready` are all 0.
- R2: Each line gives exactly CHIPS*SHIFTS_PER_CHIP rising edges of `sck` before its strobe rises.
- R3: The bytes present on `dbus` at the successive falling edges of `sck` are the accepted stream bytes, in the order they were accepted. `dbus` changes only in the cycle in which `sck` rises.
- R4: `sck` stays high for exactly SCK_HIGH cycles. Within a line, it stays low for at least SCK_LOW cycles between pulses.
- R5: The first falling `sck` edge of a line comes at least STB_TO_SCK cycles after the previous falling edge of `stb`.
- R6: `stb` rises at least SCK_TO_STB cycles after the last falling `sck` edge and stays high for exactly STB_HIGH cycles. `sck` is never high while `stb` is high.
- R7: Successive rising edges of `stb` are at least STB_PERIOD cycles apart.
- R8: A byte is taken only in a cycle with `in_valid` and `in_ready` both 1, and `sck` rises in the cycle after every such handshake and at no other time. While `in_valid` is 0, `sck` stays low.
- R9: `done` is a single-cycle pulse. It is high in the second cycle after `stb` falls, that is, one cycle after the strobe has returned low.
- R10: A `line_start` that arrives while a line is in progress has no effect. It starts no extra `sck` pulse and produces no extra `done`.
- R11: `chain_en` is 1 at every rising edge of `sck` in a line and 0 while `stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Single-cycle pulse that starts one line |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | DATA_W | Stream byte |
| sck | output | 1 | Shift clock to the chip chain |
| dbus | output | DATA_W | Parallel data bus to the chips |
| stb | output | 1 | Line strobe; the chips act on its falling edge |
| chain_en | output | 1 | Enable to the first chip of the chain, high during the shift sweep |
| done | output | 1 | One-cycle pulse after the line is latched |

## Verification
All outputs are registered on the next state, so a handshake shows up as `sck` high one cycle later, a byte lands on `dbus` in that same cycle, and `done` follows the strobe fall by one cycle. The bench timestamps every edge at the falling clock edge and compares the differences between timestamps against the parameter counts. It takes each expected byte from a queue filled at handshake time and pops it when a falling `sck` edge is seen. It also checks `done` against the recorded strobe-fall timestamp plus one. The parameters are chosen so that the strobe period and the strobe-to-clock gap actually hold the line back when a new line starts right after `done`.

// File: rtl/colchain_pkg.sv
package colchain_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_HIGH,
        S_TAIL,
        S_STB,
        S_FIN,
        S_DONE
    } line_state_e;

    localparam int N_TMR  = 3;
    localparam int T_PH   = 0;
    localparam int T_FALL = 1;
    localparam int T_RISE = 2;

endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '1;
        else if (clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int TOTAL = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] LAST_V = CW'(TOTAL - 1);

    logic [CW-1:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beats <= '0;
        else if (clr)
            beats <= '0;
        else if (inc)
            beats <= beats + 1'b1;
    end

    assign last = (beats == LAST_V);
endmodule

// File: rtl/colchain_line_loader.sv
module colchain_line_loader
    import colchain_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int CHIPS           = 12,
    parameter int SHIFTS_PER_CHIP = 20,
    parameter int SCK_HIGH        = 3,
    parameter int SCK_LOW         = 4,
    parameter int STB_TO_SCK      = 10,
    parameter int SCK_TO_STB      = 3,
    parameter int STB_HIGH        = 3,
    parameter int STB_PERIOD      = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              sck,
    output logic [DATA_W-1:0] dbus,
    output logic              stb,
    output logic              chain_en,
    output logic              done
);
    localparam int TOTAL  = CHIPS * SHIFTS_PER_CHIP;
    localparam int M1     = (SCK_HIGH > SCK_LOW) ? SCK_HIGH : SCK_LOW;
    localparam int M2     = (STB_TO_SCK > M1) ? STB_TO_SCK : M1;
    localparam int M3     = (SCK_TO_STB > M2) ? SCK_TO_STB : M2;
    localparam int M4     = (STB_HIGH > M3) ? STB_HIGH : M3;
    localparam int MAXT   = (STB_PERIOD > M4) ? STB_PERIOD : M4;
    localparam int TW     = $clog2(MAXT + 2);
    localparam int PRE_I  = (STB_TO_SCK > SCK_HIGH + 1) ? STB_TO_SCK - SCK_HIGH - 1 : 0;

    localparam logic [TW-1:0] HIGH_LAST = TW'(SCK_HIGH - 1);
    localparam logic [TW-1:0] LOW_LAST  = TW'(SCK_LOW - 1);
    localparam logic [TW-1:0] TAIL_LAST = TW'(SCK_TO_STB - 1);
    localparam logic [TW-1:0] STBH_LAST = TW'(STB_HIGH - 1);
    localparam logic [TW-1:0] PER_LAST  = TW'(STB_PERIOD - 1);
    localparam logic [TW-1:0] PRE_RISE  = TW'(PRE_I);

    line_state_e state_q, state_d;

    logic [N_TMR-1:0] tmr_clr;
    logic [TW-1:0]    tmr [N_TMR];
    logic             last_beat;
    logic             accept;

    // Timers: phase length, time since strobe fall, time since strobe rise
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        pace_timer #(.W(TW)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (tmr_clr[g]),
            .cnt   (tmr[g])
        );
    end

    beat_counter #(.TOTAL(TOTAL)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_IDLE),
        .inc   (state_q == S_HIGH && state_d != S_HIGH),
        .last  (last_beat)
    );

    assign in_ready = (state_q == S_LOAD)
                   && (tmr[T_PH] >= LOW_LAST)
                   && (tmr[T_FALL] >= PRE_RISE);
    assign accept   = in_valid && in_ready;

    assign tmr_clr[T_PH]   = (state_q != state_d);
    assign tmr_clr[T_FALL] = (state_q == S_STB) && (state_d == S_FIN);
    assign tmr_clr[T_RISE] = (state_q == S_TAIL) && (state_d == S_STB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (line_start) state_d = S_LOAD;
            S_LOAD: if (accept) state_d = S_HIGH;
            S_HIGH: if (tmr[T_PH] >= HIGH_LAST)
                        state_d = last_beat ? S_TAIL : S_LOAD;
            S_TAIL: if (tmr[T_PH] >= TAIL_LAST && tmr[T_RISE] >= PER_LAST)
                        state_d = S_STB;
            S_STB:  if (tmr[T_PH] >= STBH_LAST) state_d = S_FIN;
            S_FIN:  state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck      <= 1'b0;
            stb      <= 1'b0;
            done     <= 1'b0;
            chain_en <= 1'b0;
            dbus     <= '0;
        end else begin
            sck      <= (state_d == S_HIGH);
            stb      <= (state_d == S_STB);
            done     <= (state_d == S_DONE);
            chain_en <= (state_d == S_LOAD) || (state_d == S_HIGH);
            if (accept)
                dbus <= in_data;
        end
    end
endmodule

// File: rtl/colchain_line_loader_chk.sv
module colchain_line_loader_chk #(
    parameter int DATA_W   = 8,
    parameter int SCK_HIGH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              stb,
    input logic              done,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] dbus
);
    localparam int HW = $clog2(SCK_HIGH + 2);
    localparam logic [HW-1:0] HIGH_V = HW'(SCK_HIGH);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!sck)
            hi_cnt <= '0;
        else if (hi_cnt != '1)
            hi_cnt <= hi_cnt + 1'b1;
    end

    assert_sck_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> (hi_cnt == HIGH_V));

    assert_dbus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sck) |-> $stable(dbus));

    assert_strobe_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> !sck);

    assert_accept_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> $rose(sck));

    assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!$past(stb) && $past(stb, 2)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind colchain_line_loader colchain_line_loader_chk #(
    .DATA_W   (DATA_W),
    .SCK_HIGH (SCK_HIGH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .stb      (stb),
    .done     (done),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .dbus     (dbus)
);

// File: tb/tb_colchain_line_loader.sv
module tb_colchain_line_loader;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CH = 3;
    localparam int SPC = 4;
    localparam int TOT = CH * SPC;
    localparam int HI = 3;
    localparam int LO = 4;
    localparam int S2C = 10;
    localparam int C2S = 3;
    localparam int SH = 3;
    localparam int PER = 120;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_data = '0;
    logic sck, stb, chain_en, done;
    logic [DW-1:0] dbus;

    always #(CLK_PERIOD / 2) clk = ~clk;

    colchain_line_loader #(
        .DATA_W(DW), .CHIPS(CH), .SHIFTS_PER_CHIP(SPC), .SCK_HIGH(HI), .SCK_LOW(LO),
        .STB_TO_SCK(S2C), .SCK_TO_STB(C2S), .STB_HIGH(SH), .STB_PERIOD(PER)
    ) dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .sck(sck), .dbus(dbus), .stb(stb),
        .chain_en(chain_en), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard queue: the driver pushes bytes at handshake, the monitor pops them
    logic [DW-1:0] exp_q [$];
    logic acc = 1'b0;
    bit feed_on = 1'b0;
    bit gappy = 1'b0;
    int kidx = 0;
    int dcyc = 0;

    always @(posedge clk) acc <= in_valid && in_ready;

    always @(negedge clk) begin
        dcyc++;
        if (acc) begin
            exp_q.push_back(in_data);
            kidx++;
            in_data = DW'(kidx * 37 + 5);
        end
        in_valid = feed_on && !(gappy && (dcyc % 3 == 0));
    end

    // Monitor
    int n = 0;
    int t_sck_rise = -100000, t_sck_fall = -100000;
    int t_stb_rise = -100000, t_stb_fall = -100000;
    bit first_rise_stb = 1'b1;
    bit first_in_line = 1'b1;
    int rises_line = 0;
    int done_cnt = 0;
    logic p_sck = 1'b0, p_stb = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            n++;
            if (sck && !p_sck) begin
                check(acc == 1'b1, "R8 rise follows handshake", int'(acc), 1);
                check(chain_en == 1'b1, "R11 chain_en at rise", int'(chain_en), 1);
                if (!first_in_line)
                    check(n - t_sck_fall >= LO, "R4 low phase", n - t_sck_fall, LO);
                rises_line++;
                t_sck_rise = n;
            end else if (acc) begin
                check(1'b0, "R8 handshake without rise", 0, 1);
            end
            if (!sck && p_sck) begin
                check(n - t_sck_rise == HI, "R4 high phase", n - t_sck_rise, HI);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 byte without handshake", int'(dbus), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(dbus == e, "R3 byte order", int'(dbus), int'(e));
                end
                if (first_in_line)
                    check(n - t_stb_fall >= S2C, "R5 strobe to first fall", n - t_stb_fall, S2C);
                first_in_line = 1'b0;
                t_sck_fall = n;
            end
            if (stb && !p_stb) begin
                check(rises_line == TOT, "R2 pulses per line", rises_line, TOT);
                check(n - t_sck_fall >= C2S, "R6 last fall to strobe", n - t_sck_fall, C2S);
                check(chain_en == 1'b0, "R11 chain_en during strobe", int'(chain_en), 0);
                if (!first_rise_stb)
                    check(n - t_stb_rise >= PER, "R7 strobe period", n - t_stb_rise, PER);
                first_rise_stb = 1'b0;
                t_stb_rise = n;
                rises_line = 0;
                first_in_line = 1'b1;
            end
            if (stb && sck)
                check(1'b0, "R6 sck high during strobe", 1, 0);
            if (!stb && p_stb) begin
                check(n - t_stb_rise == SH, "R6 strobe width", n - t_stb_rise, SH);
                t_stb_fall = n;
            end
            if (done) begin
                check(n == t_stb_fall + 1, "R9 done timing", n, t_stb_fall + 1);
                check(!p_done, "R9 done single", int'(p_done), 0);
                done_cnt++;
            end
            p_sck = sck;
            p_stb = stb;
            p_done = done;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic wait_done(input int target);
        while (done_cnt < target) @(posedge clk);
    endtask

    initial begin
        int hold_rises;
        repeat (3) @(negedge clk);
        check({sck, stb, done, chain_en, in_ready} == 5'b0, "R1 in reset",
              int'({sck, stb, done, chain_en, in_ready}), 0);
        rst_n = 1'b1;
        feed_on = 1'b1;
        repeat (4) @(negedge clk);
        check({sck, stb, done, chain_en, in_ready} == 5'b0, "R1 after reset",
              int'({sck, stb, done, chain_en, in_ready}), 0);

        // Line A: continuous stream, extra start pulse mid-line
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_done(1);
        repeat (40) @(negedge clk);
        check(rises_line == 0, "R10 no activity after ignored start", rises_line, 0);
        check(done_cnt == 1, "R10 one done per line", done_cnt, 1);

        // Line B: gappy stream with a long stall
        gappy = 1'b1;
        pulse_start();
        repeat (30) @(negedge clk);
        feed_on = 1'b0;
        repeat (2) @(negedge clk);
        hold_rises = rises_line;
        repeat (40) @(negedge clk);
        check(rises_line == hold_rises, "R8 stalled without valid", rises_line, hold_rises);
        check(sck == 1'b0, "R8 sck low while stalled", int'(sck), 0);
        feed_on = 1'b1;
        wait_done(2);

        // Line C: back-to-back, strobe period and strobe-to-clock gap bind
        gappy = 1'b0;
        pulse_start();
        wait_done(3);
        repeat (10) @(negedge clk);
        check(done_cnt == 3, "R10 total done count", done_cnt, 3);
        check(exp_q.size() == 0, "R3 all bytes shifted", exp_q.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", done_cnt, 3);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule